// File: doc/BRIEF.md
# Keyed-Access Watchdog Timer

This block is a watchdog that counts cycles of a fixed reference clock and, if software fails to restart it in time, raises a one-cycle request to the system reset network. Its control word and its restart action both sit behind a small register port. Neither can be reached by one stray write. A new control value is taken only as the third of three consecutive writes to the control address, and the first two must be the two unlock keys in order. The count is restarted only by a different pair of keys, also in order.

The timeout is chosen by an exponent select. Selections 25 to 30 give a terminal count of 2 to that power of reference clocks, roughly one to thirty-two seconds at the intended clock. A scale parameter lowers every exponent by a fixed amount so that a simulation reaches expiry in a short run. When reset generation is turned off, expiry only raises a sticky timeout flag. A status register survives the reset the watchdog itself causes, because only the power-on reset clears it. This lets software learn why the system restarted. Software clears the flags it has seen by writing ones to them.

Top module: `kwdt_top`

## Requirements
- R1: After power-on reset the control word reads 0x401E: bit 15 (count enable) is 0, bit 14 (reset enable) is 1, bits 4:0 (exponent select) are 30, and every other bit is 0. The status register reads 0 and the reset request is low.
- R2: A write to the control address (0) changes the control word only when the two writes to that address just before it were the unlock keys, first 0x3333 and then 0xCCCC. Any value, including a key value, is then taken as the new control word. Writes to other addresses do not advance or break the sequence.
- R3: A write to the control address that breaks a sequence, whether it is a wrong key or a key out of order, returns the sequencer to idle. The control word and the count stay unchanged.
- R4: Writing restart key 0xAAAA and then 0x5555 to the control address sets the count to zero. Any other second write cancels the restart and leaves the count running.
- R5: With counting enabled, expiry occurs 2^(S - EXP_SCALE) reference cycles after the edge that enabled or restarted the count, where S is the exponent select clamped to the range 25 to 30. Selections below 25 act as 25 and selections above 30 act as 30.
- R6: While the count enable is 0, the count is held at zero and no expiry occurs.
- R7: On expiry with reset enable set, the reset request is high for exactly one cycle, in the same cycle that status bit 0 (watchdog reset seen) becomes 1.
- R8: On expiry with reset enable clear, the reset request stays low and status bit 1 (timeout seen) becomes 1. After expiry the count restarts from zero.
- R9: Status bits keep their value through the system reset and clear only on power-on reset or on a write of 1 to that bit at the status address (1). Writing 0 to a bit leaves it as it was.
- R10: When a clear and a new watchdog event hit the same status bit in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| por_n | input | 1 | Power-on reset, active low; clears everything including status |
| rst_n | input | 1 | System reset, active low; clears everything except status |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address: 0 control, 1 status |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
The bound checker watches, on every cycle, that the control word changes only after an armed sequencer has taken a control write. It also watches that the reset request is a single-cycle pulse that needs reset enable and comes with the status flag, that the count stays at zero while counting is disabled, that expiry sets its flag even under a clear, and that a flag drops only on a status write of one. Only the directed scenarios can show the exact expiry cycle for each exponent and for the clamped selections. They also show how restart keys move expiry later, that broken sequences of several shapes leave the control word and the count untouched, and that the status register survives the system reset.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;

   localparam int WORD_W = 16;
   localparam int SEL_W  = 5;

   localparam int BIT_EN    = 15;
   localparam int BIT_RSTEN = 14;

   typedef struct packed {
      logic             en;
      logic             rst_en;
      logic [SEL_W-1:0] sel;
   } ctrl_t;

   typedef enum logic [1:0] {
      SEQ_IDLE  = 2'd0,
      SEQ_UNLK1 = 2'd1,
      SEQ_ARMED = 2'd2,
      SEQ_RST1  = 2'd3
   } seq_state_t;

   localparam ctrl_t CTRL_DEFAULT = '{en: 1'b0, rst_en: 1'b1, sel: 5'd30};

   function automatic ctrl_t unpack_ctrl(input logic [WORD_W-1:0] w);
      ctrl_t c;
      c.en     = w[BIT_EN];
      c.rst_en = w[BIT_RSTEN];
      c.sel    = w[SEL_W-1:0];
      return c;
   endfunction

   function automatic logic [WORD_W-1:0] pack_ctrl(input ctrl_t c);
      logic [WORD_W-1:0] w;
      w                = '0;
      w[BIT_EN]        = c.en;
      w[BIT_RSTEN]     = c.rst_en;
      w[SEL_W-1:0]     = c.sel;
      return w;
   endfunction

endpackage

// File: rtl/kwdt_keyseq.sv
module kwdt_keyseq
   import kwdt_pkg::*;
#(
   parameter logic [WORD_W-1:0] KEY_UNLOCK_A  = 16'h3333,
   parameter logic [WORD_W-1:0] KEY_UNLOCK_B  = 16'hCCCC,
   parameter logic [WORD_W-1:0] KEY_RESTART_A = 16'hAAAA,
   parameter logic [WORD_W-1:0] KEY_RESTART_B = 16'h5555
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctrl_wr,
   input  logic [WORD_W-1:0] wdata,
   output logic              load,
   output logic              restart,
   output logic              armed
);

   seq_state_t state_q, state_d;

   always_comb begin
      state_d = state_q;
      load    = 1'b0;
      restart = 1'b0;
      if (ctrl_wr) begin
         unique case (state_q)
            SEQ_IDLE: begin
               if (wdata == KEY_UNLOCK_A)
                  state_d = SEQ_UNLK1;
               else if (wdata == KEY_RESTART_A)
                  state_d = SEQ_RST1;
               else
                  state_d = SEQ_IDLE;
            end
            SEQ_UNLK1: begin
               state_d = (wdata == KEY_UNLOCK_B) ? SEQ_ARMED : SEQ_IDLE;
            end
            SEQ_ARMED: begin
               load    = 1'b1;
               state_d = SEQ_IDLE;
            end
            SEQ_RST1: begin
               restart = (wdata == KEY_RESTART_B);
               state_d = SEQ_IDLE;
            end
            default: state_d = SEQ_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         state_q <= SEQ_IDLE;
      else
         state_q <= state_d;
   end

   assign armed = (state_q == SEQ_ARMED);

endmodule

// File: rtl/kwdt_counter.sv
module kwdt_counter
   import kwdt_pkg::*;
#(
   parameter int EXP_MIN   = 25,
   parameter int EXP_MAX   = 30,
   parameter int EXP_SCALE = 20,
   localparam int NSEL  = EXP_MAX - EXP_MIN + 1,
   localparam int CNT_W = EXP_MAX - EXP_SCALE
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             restart,
   input  logic [SEL_W-1:0] sel,
   output logic [CNT_W-1:0] cnt,
   output logic             expire
);

   localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};

   logic [SEL_W-1:0] sel_c;
   logic [NSEL-1:0]  pick;
   logic [NSEL-1:0]  hit;
   logic [CNT_W-1:0] cnt_q, cnt_d;

   always_comb begin
      if (sel < SEL_W'(EXP_MIN))
         sel_c = SEL_W'(EXP_MIN);
      else if (sel > SEL_W'(EXP_MAX))
         sel_c = SEL_W'(EXP_MAX);
      else
         sel_c = sel;
   end

   for (genvar i = 0; i < NSEL; i++) begin : g_term
      localparam logic [CNT_W-1:0] LIM = ALL_ONES >> (NSEL - 1 - i);
      assign pick[i] = (sel_c == SEL_W'(EXP_MIN + i));
      assign hit[i]  = (cnt_q == LIM);
   end

   assign expire = en && (|(pick & hit));

   always_comb begin
      if (restart || !en || expire)
         cnt_d = '0;
      else
         cnt_d = cnt_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else
         cnt_q <= cnt_d;
   end

   assign cnt = cnt_q;

endmodule

// File: rtl/kwdt_status.sv
module kwdt_status #(
   parameter int NFLAG = 2
)(
   input  logic             clk,
   input  logic             por_n,
   input  logic [NFLAG-1:0] set,
   input  logic             clr_wr,
   input  logic [NFLAG-1:0] clr_mask,
   output logic [NFLAG-1:0] flags
);

   logic [NFLAG-1:0] q;

   for (genvar i = 0; i < NFLAG; i++) begin : g_flag
      always_ff @(posedge clk or negedge por_n) begin
         if (!por_n)
            q[i] <= 1'b0;
         else if (set[i])
            q[i] <= 1'b1;
         else if (clr_wr && clr_mask[i])
            q[i] <= 1'b0;
      end
   end

   assign flags = q;

endmodule

// File: rtl/kwdt_top.sv
module kwdt_top
   import kwdt_pkg::*;
#(
   parameter int ADDR_W    = 2,
   parameter int EXP_MIN   = 25,
   parameter int EXP_MAX   = 30,
   parameter int EXP_SCALE = 20,
   parameter logic [ADDR_W-1:0] CTRL_ADDR = 'd0,
   parameter logic [ADDR_W-1:0] STAT_ADDR = 'd1,
   parameter logic [WORD_W-1:0] KEY_UNLOCK_A  = 16'h3333,
   parameter logic [WORD_W-1:0] KEY_UNLOCK_B  = 16'hCCCC,
   parameter logic [WORD_W-1:0] KEY_RESTART_A = 16'hAAAA,
   parameter logic [WORD_W-1:0] KEY_RESTART_B = 16'h5555
)(
   input  logic              clk,
   input  logic              por_n,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [WORD_W-1:0] bus_wdata,
   output logic [WORD_W-1:0] bus_rdata,
   output logic              rst_req
);

   localparam int CNT_W = EXP_MAX - EXP_SCALE;
   localparam int NFLAG = 2;

   if (EXP_SCALE < 0 || EXP_SCALE >= EXP_MIN) begin : g_bad_scale
      $error("EXP_SCALE must lie in 0 .. EXP_MIN-1");
   end
   if (EXP_MAX < EXP_MIN || EXP_MAX >= (1 << SEL_W)) begin : g_bad_range
      $error("exponent range must fit the select field");
   end
   if (CTRL_ADDR == STAT_ADDR) begin : g_bad_addr
      $error("control and status addresses must differ");
   end
   if (KEY_UNLOCK_A == KEY_RESTART_A) begin : g_bad_keys
      $error("first unlock and first restart keys must differ");
   end

   logic              core_rst_n;
   logic              wr_ctrl;
   logic              wr_stat;
   logic              seq_load;
   logic              seq_restart;
   logic              seq_armed;
   ctrl_t             ctrl_q;
   logic [WORD_W-1:0] ctrl_word;
   logic [CNT_W-1:0]  cnt;
   logic              expire;
   logic [NFLAG-1:0]  stat_set;
   logic [NFLAG-1:0]  stat_q;
   logic              req_q;

   assign core_rst_n = rst_n & por_n;
   assign wr_ctrl    = bus_wr && (bus_addr == CTRL_ADDR);
   assign wr_stat    = bus_wr && (bus_addr == STAT_ADDR);

   kwdt_keyseq #(
      .KEY_UNLOCK_A  (KEY_UNLOCK_A),
      .KEY_UNLOCK_B  (KEY_UNLOCK_B),
      .KEY_RESTART_A (KEY_RESTART_A),
      .KEY_RESTART_B (KEY_RESTART_B)
   ) i_seq (
      .clk     (clk),
      .rst_n   (core_rst_n),
      .ctrl_wr (wr_ctrl),
      .wdata   (bus_wdata),
      .load    (seq_load),
      .restart (seq_restart),
      .armed   (seq_armed)
   );

   always_ff @(posedge clk or negedge core_rst_n) begin
      if (!core_rst_n)
         ctrl_q <= CTRL_DEFAULT;
      else if (seq_load)
         ctrl_q <= unpack_ctrl(bus_wdata);
   end

   assign ctrl_word = pack_ctrl(ctrl_q);

   kwdt_counter #(
      .EXP_MIN   (EXP_MIN),
      .EXP_MAX   (EXP_MAX),
      .EXP_SCALE (EXP_SCALE)
   ) i_cnt (
      .clk     (clk),
      .rst_n   (core_rst_n),
      .en      (ctrl_q.en),
      .restart (seq_restart),
      .sel     (ctrl_q.sel),
      .cnt     (cnt),
      .expire  (expire)
   );

   assign stat_set[0] = expire &&  ctrl_q.rst_en;
   assign stat_set[1] = expire && !ctrl_q.rst_en;

   kwdt_status #(
      .NFLAG (NFLAG)
   ) i_stat (
      .clk      (clk),
      .por_n    (por_n),
      .set      (stat_set),
      .clr_wr   (wr_stat),
      .clr_mask (bus_wdata[NFLAG-1:0]),
      .flags    (stat_q)
   );

   always_ff @(posedge clk or negedge core_rst_n) begin
      if (!core_rst_n)
         req_q <= 1'b0;
      else
         req_q <= stat_set[0];
   end

   assign rst_req = req_q;

   always_comb begin
      if (bus_addr == CTRL_ADDR)
         bus_rdata = ctrl_word;
      else if (bus_addr == STAT_ADDR)
         bus_rdata = {{(WORD_W-NFLAG){1'b0}}, stat_q};
      else
         bus_rdata = '0;
   end

endmodule

// File: rtl/kwdt_chk.sv
module kwdt_chk #(
   parameter int CNT_W = 10
)(
   input logic             clk,
   input logic             por_n,
   input logic             core_rst_n,
   input logic             wr_ctrl,
   input logic             wr_stat,
   input logic [1:0]       clr_bits,
   input logic             seq_armed,
   input logic [15:0]      ctrl_word,
   input logic [CNT_W-1:0] cnt,
   input logic             expire,
   input logic [1:0]       stat_q,
   input logic             rst_req
);

   p_ctrl_keyed_r2: assert property (@(posedge clk) disable iff (!core_rst_n)
      !$stable(ctrl_word) |-> ($past(seq_armed) && $past(wr_ctrl)));

   p_hold_zero_r6: assert property (@(posedge clk) disable iff (!core_rst_n)
      !ctrl_word[15] |=> (cnt == '0));

   p_req_pulse_r7: assert property (@(posedge clk) disable iff (!core_rst_n)
      rst_req |=> !rst_req);

   p_req_flag_r7: assert property (@(posedge clk) disable iff (!core_rst_n)
      rst_req |-> stat_q[0]);

   p_req_needs_rsten_r8: assert property (@(posedge clk) disable iff (!core_rst_n)
      rst_req |-> $past(ctrl_word[14]));

   p_timeout_set_r10: assert property (@(posedge clk) disable iff (!core_rst_n)
      (expire && !ctrl_word[14]) |=> stat_q[1]);

   p_wdt_sticky_r9: assert property (@(posedge clk) disable iff (!por_n)
      ($past(stat_q[0]) && !stat_q[0]) |-> ($past(wr_stat) && $past(clr_bits[0])));

   p_to_sticky_r9: assert property (@(posedge clk) disable iff (!por_n)
      ($past(stat_q[1]) && !stat_q[1]) |-> ($past(wr_stat) && $past(clr_bits[1])));

endmodule

bind kwdt_top kwdt_chk #(
   .CNT_W (CNT_W)
) i_chk (
   .clk        (clk),
   .por_n      (por_n),
   .core_rst_n (core_rst_n),
   .wr_ctrl    (wr_ctrl),
   .wr_stat    (wr_stat),
   .clr_bits   (bus_wdata[1:0]),
   .seq_armed  (seq_armed),
   .ctrl_word  (ctrl_word),
   .cnt        (cnt),
   .expire     (expire),
   .stat_q     (stat_q),
   .rst_req    (rst_req)
);

// File: tb/test_kwdt_top.sv
module test_kwdt_top;

   localparam logic [1:0]  A_CTRL = 2'd0;
   localparam logic [1:0]  A_STAT = 2'd1;
   localparam logic [15:0] UA = 16'h3333;
   localparam logic [15:0] UB = 16'hCCCC;
   localparam logic [15:0] RA = 16'hAAAA;
   localparam logic [15:0] RB = 16'h5555;

   logic        clk = 1'b0;
   logic        por_n = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [1:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        rst_req;

   int cyc = 0;
   int n_run = 0;
   int n_fail = 0;
   bit done = 0;

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   kwdt_top i_kwdt_top (
      .clk       (clk),
      .por_n     (por_n),
      .rst_n     (rst_n),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .rst_req   (rst_req)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      @(negedge clk);
      bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(input logic [1:0] a, output int d);
      bus_addr = a;
      #1;
      d = int'(bus_rdata);
   endtask

   task automatic ctrl_write(input logic [15:0] v);
      wr(A_CTRL, UA);
      wr(A_CTRL, UB);
      wr(A_CTRL, v);
   endtask

   task automatic do_por();
      @(negedge clk);
      por_n = 1'b0; rst_n = 1'b0;
      repeat (2) @(negedge clk);
      por_n = 1'b1; rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic wait_until(input int c);
      while (cyc < c) @(negedge clk);
   endtask

   task automatic wait_req(input int ref_c, input int limit, output int diff);
      diff = -1;
      while (cyc - ref_c < limit) begin
         @(negedge clk);
         if (rst_req) begin
            diff = cyc - ref_c;
            break;
         end
      end
   endtask

   task automatic t_reset();
      int d;
      do_por();
      rd(A_CTRL, d); chk("R1 control default", d, 16'h401E);
      rd(A_STAT, d); chk("R1 status default", d, 0);
      chk("R1 request low", int'(rst_req), 0);
      wait_req(cyc, 1100, d);
      chk("R6 no expiry while disabled", d, -1);
      rd(A_STAT, d); chk("R6 status untouched while disabled", d, 0);
   endtask

   task automatic t_unlock();
      int d;
      do_por();
      ctrl_write(16'h4019);
      rd(A_CTRL, d); chk("R2 keyed write lands", d, 16'h4019);
      wr(A_CTRL, UA); wr(A_CTRL, 16'h1234); wr(A_CTRL, 16'h0005);
      rd(A_CTRL, d); chk("R3 wrong second key", d, 16'h4019);
      wr(A_CTRL, UB); wr(A_CTRL, UA); wr(A_CTRL, 16'h0006);
      rd(A_CTRL, d); chk("R3 keys out of order", d, 16'h4019);
      wr(A_CTRL, UA); wr(A_CTRL, RA); wr(A_CTRL, 16'h0007);
      rd(A_CTRL, d); chk("R3 restart key breaks unlock", d, 16'h4019);
      wr(A_CTRL, 16'h0008);
      rd(A_CTRL, d); chk("R3 plain write ignored", d, 16'h4019);
      wr(A_CTRL, UA); wr(A_CTRL, UB); wr(A_STAT, 16'h0000); wr(A_CTRL, 16'h401A);
      rd(A_CTRL, d); chk("R2 other address does not break sequence", d, 16'h401A);
      ctrl_write(UA);
      rd(A_CTRL, d); chk("R2 key value taken as data", d, int'(UA & 16'hC01F));
   endtask

   task automatic t_expire_reset();
      int d, e;
      do_por();
      ctrl_write(16'hC019);
      e = cyc;
      wait_req(e, 40, d); chk("R5 R7 period sel 25", d, 32);
      rd(A_STAT, d); chk("R7 wdt flag set", d, 1);
      @(negedge clk);
      chk("R7 request one cycle", int'(rst_req), 0);
      @(negedge clk); rst_n = 1'b0;
      repeat (3) @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      rd(A_STAT, d); chk("R9 flag survives system reset", d, 1);
      rd(A_CTRL, d); chk("R9 control back to default", d, 16'h401E);
      wr(A_STAT, 16'h0000);
      rd(A_STAT, d); chk("R9 write zero keeps flag", d, 1);
      wr(A_STAT, 16'h0001);
      rd(A_STAT, d); chk("R9 write one clears flag", d, 0);
   endtask

   task automatic t_periods();
      int d, e;
      do_por();
      ctrl_write(16'hC01A); e = cyc;
      wait_req(e, 80, d); chk("R5 period sel 26", d, 64);
      do_por();
      ctrl_write(16'hC014); e = cyc;
      wait_req(e, 80, d); chk("R5 clamp low sel 20", d, 32);
      do_por();
      ctrl_write(16'hC01F); e = cyc;
      wait_req(e, 1100, d); chk("R5 clamp high sel 31", d, 1024);
   endtask

   task automatic t_restart();
      int d, e, r;
      do_por();
      ctrl_write(16'hC019); e = cyc;
      wait_until(e + 20);
      wr(A_CTRL, RA); wr(A_CTRL, RB); r = cyc;
      wait_req(r, 40, d); chk("R4 restart delays expiry", d, 32);
      do_por();
      ctrl_write(16'hC019); e = cyc;
      wait_until(e + 10);
      wr(A_CTRL, RA); wr(A_CTRL, 16'h1234);
      wait_req(e, 40, d); chk("R4 broken restart keeps count", d, 32);
      do_por();
      ctrl_write(16'hC019); e = cyc;
      wait_until(e + 10);
      ctrl_write(16'h4019);
      wait_req(e, 100, d); chk("R6 disable stops count", d, -1);
   endtask

   task automatic t_timeout();
      int d, e;
      do_por();
      ctrl_write(16'h8019); e = cyc;
      wait_req(e, 40, d); chk("R8 no request without reset enable", d, -1);
      rd(A_STAT, d); chk("R8 timeout flag set", d, 2);
      wr(A_STAT, 16'h0002);
      rd(A_STAT, d); chk("R9 timeout flag cleared", d, 0);
      wait_until(e + 63);
      wr(A_STAT, 16'h0002);
      rd(A_STAT, d); chk("R10 set wins over clear", d, 2);
      wait_req(e + 64, 40, d); chk("R8 count restarts after expiry", d, -1);
      rd(A_STAT, d); chk("R8 second timeout keeps flag", d, 2);
      do_por();
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   initial begin
      t_reset();
      t_unlock();
      t_expire_reset();
      t_periods();
      t_restart();
      t_timeout();
      finish_run();
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
   end

endmodule